// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block is a bank of general-purpose I/O pins. A direction bit makes each pin an input or an output. A single data/status register holds the value that output pins drive and the state that input pins sense. Three write-one ports set, clear or invert any chosen group of data bits in one bus write. Bits written as zero are left alone, so software never needs a read-modify-write. The same three write ports exist for each of two interrupt mask registers.

Each input pin passes through a two-flop synchronizer. It can then be inverted by a per-pin polarity bit. In level mode the data bit follows the pin. In edge mode an event latches the data bit, and the bit stays set until software clears it. A further per-pin bit picks rising-only or both-edge detection. Each interrupt output is high when any data bit is set together with its bit in that output's mask. An output pin can therefore raise an interrupt purely from a software write to its data bit.

The register port is a plain write strobe with address and data. Read data is combinational from the addressed register.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, all pins are inputs (`pinOe` = 0) and both interrupt outputs are low.
- R2: `pinOe` equals the direction register (1 = output), and `pinOut` equals the data register.
- R3: Writing address 0 (data), 4 (mask A), 8 (mask B), 12 (direction), 13 (polarity), 14 (edge select) or 15 (both-edge) loads the full word. A read of any address returns the register of its group: addresses 0-3 return data, 4-7 mask A, 8-11 mask B, and 12-15 the configuration register named above.
- R4: A write to address 1 sets each data bit whose write-data bit is 1 on output and edge-mode pins. Bits written 0 keep their value.
- R5: A write to address 2 clears each data bit whose write-data bit is 1, on output pins and on latched edge-mode inputs.
- R6: A write to address 3 inverts each data bit whose write-data bit is 1 on output pins.
- R7: Mask A is set, cleared and toggled through addresses 5, 6 and 7. Mask B uses addresses 9, 10 and 11. Each port changes only the bits written as 1.
- R8: For an input pin in level mode (edge bit 0), the data bit equals the pin XOR its polarity bit. It shows a pin change after the third rising clock edge and a polarity change after the second. Software writes to such a bit do not persist.
- R9: For an input pin in edge mode with the both-edge bit 0, a rising sensed edge sets the data bit. The bit stays set until cleared, and a falling edge sets nothing.
- R10: For an input pin in edge mode with the both-edge bit 1, both rising and falling sensed edges set the data bit.
- R11: A polarity bit of 1 inverts the sensed pin, so in rising-only mode a falling pin edge latches the bit and a rising one does not.
- R12: `irqA` is the OR over pins of (data AND mask A), and `irqB` is the same with mask B. This holds for both input-sensed bits and software-written output bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 4 | Register address |
| busWrData | input | NUM_PINS | Write data |
| busRdData | output | NUM_PINS | Read data of the addressed register group |
| pinIn | input | NUM_PINS | Asynchronous pin levels |
| pinOut | output | NUM_PINS | Values driven on output pins |
| pinOe | output | NUM_PINS | Output enables (1 = drive) |
| irqA | output | 1 | Interrupt from mask set A |
| irqB | output | 1 | Interrupt from mask set B |

## Verification
The data register is both what output pins drive and what the interrupts see. A corrupt bit therefore shows on `pinOut` and, where unmasked, on `irqA`/`irqB` in the cycle after the faulty update. A wrong edge-detect history shows as a missing or spurious latch, three clock edges after the pin moves. A mask-port decode error shows on the next read and on the interrupt lines at once. The bench checks each write port against a model of the whole word, and it checks that edge latches survive opposite edges and idle cycles.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int NUM_IRQ = 2;

  // Register map: [3:2] selects the group, [1:0] the access kind within it.
  typedef enum logic [3:0] {
    REG_DATA      = 4'd0,
    REG_DATA_SET  = 4'd1,
    REG_DATA_CLR  = 4'd2,
    REG_DATA_TGL  = 4'd3,
    REG_MASKA     = 4'd4,
    REG_MASKA_SET = 4'd5,
    REG_MASKA_CLR = 4'd6,
    REG_MASKA_TGL = 4'd7,
    REG_MASKB     = 4'd8,
    REG_MASKB_SET = 4'd9,
    REG_MASKB_CLR = 4'd10,
    REG_MASKB_TGL = 4'd11,
    REG_DIR       = 4'd12,
    REG_POL       = 4'd13,
    REG_EDGE      = 4'd14,
    REG_BOTH      = 4'd15
  } reg_addr_e;

  // One-hot write operation: bit0 load, bit1 set, bit2 clear, bit3 toggle.
  typedef logic [3:0] wr_op_t;

  typedef struct packed {
    wr_op_t                dataOp;
    wr_op_t [NUM_IRQ-1:0]  maskOp;
  } strobe_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] chainQ;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chainQ[0] <= '0;
          else       chainQ[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chainQ[s] <= '0;
          else       chainQ[s] <= chainQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chainQ[STAGES-1];

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               busWrEn,
  input  logic [3:0]                         busAddr,
  input  logic [NUM_PINS-1:0]                busWrData,
  input  logic [NUM_PINS-1:0]                dataQ,
  input  logic [NUM_IRQ-1:0][NUM_PINS-1:0]   maskQ,
  output strobe_t                            strb,
  output logic [NUM_PINS-1:0]                dirQ,
  output logic [NUM_PINS-1:0]                polQ,
  output logic [NUM_PINS-1:0]                edgeQ,
  output logic [NUM_PINS-1:0]                bothQ,
  output logic [NUM_PINS-1:0]                busRdData
);

  localparam logic [1:0] GROUP_DATA = 2'd0;
  localparam logic [1:0] GROUP_CFG  = 2'd3;

  logic [1:0] groupSel;
  logic [1:0] opSel;
  wr_op_t     opVec;

  assign groupSel = busAddr[3:2];
  assign opSel    = busAddr[1:0];
  assign opVec    = wr_op_t'(4'b0001 << opSel);

  always_comb begin
    strb.dataOp = (busWrEn && groupSel == GROUP_DATA) ? opVec : '0;
  end

  genvar k;
  generate
    for (k = 0; k < NUM_IRQ; k++) begin : g_maskStrb
      always_comb begin
        strb.maskOp[k] = (busWrEn && groupSel == 2'(k + 1)) ? opVec : '0;
      end
    end
  endgenerate

  // Configuration registers live in the last address group.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ  <= '0;
      polQ  <= '0;
      edgeQ <= '0;
      bothQ <= '0;
    end else if (busWrEn && groupSel == GROUP_CFG) begin
      unique case (opSel)
        2'd0: dirQ  <= busWrData;
        2'd1: polQ  <= busWrData;
        2'd2: edgeQ <= busWrData;
        default: bothQ <= busWrData;
      endcase
    end
  end

  always_comb begin
    unique case (groupSel)
      2'd0: busRdData = dataQ;
      2'd1: busRdData = maskQ[0];
      2'd2: busRdData = maskQ[1];
      default: begin
        unique case (opSel)
          2'd0: busRdData = dirQ;
          2'd1: busRdData = polQ;
          2'd2: busRdData = edgeQ;
          default: busRdData = bothQ;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  strobe_t                            strb,
  input  logic [NUM_PINS-1:0]                wrData,
  input  logic [NUM_PINS-1:0]                dirQ,
  input  logic [NUM_PINS-1:0]                polQ,
  input  logic [NUM_PINS-1:0]                edgeQ,
  input  logic [NUM_PINS-1:0]                bothQ,
  input  logic [NUM_PINS-1:0]                pinIn,
  output logic [NUM_PINS-1:0]                dataQ,
  output logic [NUM_IRQ-1:0][NUM_PINS-1:0]   maskQ,
  output logic [NUM_IRQ-1:0]                 irq
);

  function automatic logic [NUM_PINS-1:0] applyOp(
    input logic [NUM_PINS-1:0] cur,
    input logic [NUM_PINS-1:0] wd,
    input wr_op_t              op
  );
    logic [NUM_PINS-1:0] res;
    if (op[0]) res = wd;
    else       res = ((cur | (op[1] ? wd : '0)) & ~(op[2] ? wd : '0)) ^ (op[3] ? wd : '0);
    return res;
  endfunction

  logic [NUM_PINS-1:0] syncLevel;
  logic [NUM_PINS-1:0] sense;
  logic [NUM_PINS-1:0] senseLastQ;
  logic [NUM_PINS-1:0] riseEvt;
  logic [NUM_PINS-1:0] fallEvt;
  logic [NUM_PINS-1:0] edgeEvt;
  logic [NUM_PINS-1:0] swData;
  logic [NUM_PINS-1:0] dataD;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinIn),
    .syncOut (syncLevel)
  );

  assign sense   = syncLevel ^ polQ;
  assign riseEvt = sense & ~senseLastQ;
  assign fallEvt = ~sense & senseLastQ;
  assign edgeEvt = edgeQ & ~dirQ & (riseEvt | (bothQ & fallEvt));
  assign swData  = applyOp(dataQ, wrData, strb.dataOp);

  // Per pin: outputs take software writes only, level inputs follow the
  // sensed level, edge inputs keep software writes plus latched events
  // (an event wins over a clear in the same cycle).
  genvar i;
  generate
    for (i = 0; i < NUM_PINS; i++) begin : g_pin
      always_comb begin
        if (dirQ[i])        dataD[i] = swData[i];
        else if (!edgeQ[i]) dataD[i] = sense[i];
        else                dataD[i] = swData[i] | edgeEvt[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ      <= '0;
      senseLastQ <= '0;
    end else begin
      dataQ      <= dataD;
      senseLastQ <= sense;
    end
  end

  genvar k;
  generate
    for (k = 0; k < NUM_IRQ; k++) begin : g_mask
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) maskQ[k] <= '0;
        else       maskQ[k] <= applyOp(maskQ[k], wrData, strb.maskOp[k]);
      end
      assign irq[k] = |(dataQ & maskQ[k]);
    end
  endgenerate

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [3:0]          busAddr,
  input  logic [NUM_PINS-1:0] busWrData,
  output logic [NUM_PINS-1:0] busRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqA,
  output logic                irqB
);

  strobe_t                           strb;
  logic [NUM_PINS-1:0]               dataQ;
  logic [NUM_IRQ-1:0][NUM_PINS-1:0]  maskQ;
  logic [NUM_PINS-1:0]               dirQ;
  logic [NUM_PINS-1:0]               polQ;
  logic [NUM_PINS-1:0]               edgeQ;
  logic [NUM_PINS-1:0]               bothQ;
  logic [NUM_IRQ-1:0]                irq;

  gpio_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .dataQ     (dataQ),
    .maskQ     (maskQ),
    .strb      (strb),
    .dirQ      (dirQ),
    .polQ      (polQ),
    .edgeQ     (edgeQ),
    .bothQ     (bothQ),
    .busRdData (busRdData)
  );

  gpio_datapath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (busWrData),
    .dirQ   (dirQ),
    .polQ   (polQ),
    .edgeQ  (edgeQ),
    .bothQ  (bothQ),
    .pinIn  (pinIn),
    .dataQ  (dataQ),
    .maskQ  (maskQ),
    .irq    (irq)
  );

  assign pinOut = dataQ;
  assign pinOe  = dirQ;
  assign irqA   = irq[0];
  assign irqB   = irq[1];

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              busWrEn,
  input logic [3:0]                        busAddr,
  input logic [NUM_PINS-1:0]               busWrData,
  input logic [NUM_PINS-1:0]               dataQ,
  input logic [NUM_IRQ-1:0][NUM_PINS-1:0]  maskQ,
  input logic [NUM_PINS-1:0]               dirQ,
  input logic [NUM_PINS-1:0]               edgeQ,
  input logic                              irqA,
  input logic                              irqB
);

  // R4: written-one output bits are set next cycle
  p_data_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == REG_DATA_SET) |=>
      ((dataQ & $past(busWrData & dirQ)) == $past(busWrData & dirQ)));

  // R4: output bits written as zero keep their value
  p_data_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == REG_DATA_SET) |=>
      (((dataQ ^ $past(dataQ)) & $past(dirQ & ~busWrData)) == '0));

  // R5: written-one output bits are cleared next cycle
  p_data_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == REG_DATA_CLR) |=>
      ((dataQ & $past(busWrData & dirQ)) == '0));

  // R7: mask A set port
  p_maska_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == REG_MASKA_SET) |=>
      ((maskQ[0] & $past(busWrData)) == $past(busWrData)));

  // R7: mask B clear port
  p_maskb_clr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == REG_MASKB_CLR) |=>
      ((maskQ[1] & $past(busWrData)) == '0));

  // R9: a latched edge bit on an input survives a cycle with no bus write
  p_edge_latch_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> (($past(dataQ & edgeQ & ~dirQ) & ~dataQ) == '0));

  // R12: an empty mask keeps its interrupt low
  p_irqa_masked_r12: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ[0] == '0) |-> !irqA);

  p_irqb_masked_r12: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ[1] == '0) |-> !irqB);

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .dataQ     (dataQ),
  .maskQ     (maskQ),
  .dirQ      (dirQ),
  .edgeQ     (edgeQ),
  .irqA      (irqA),
  .irqB      (irqB)
);

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busWrEn = 1'b0;
  logic [3:0]   busAddr = '0;
  logic [W-1:0] busWrData = '0;
  logic [W-1:0] busRdData;
  logic [W-1:0] pinIn = '0;
  logic [W-1:0] pinOut;
  logic [W-1:0] pinOe;
  logic         irqA;
  logic         irqB;

  always #2 clk = ~clk;  // 250 MHz

  gpio_irq_bank #(.NUM_PINS(W)) dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqA(irqA), .irqB(irqB)
  );

  // Observation selectors
  localparam int OBS_RD = 0, OBS_IRQA = 1, OBS_IRQB = 2, OBS_OE = 3, OBS_OUT = 4;

  typedef struct {
    int           sel;
    logic [W-1:0] exp;
    logic [W-1:0] msk;
    string        tag;
  } item_t;

  item_t q[$];
  item_t cur;
  logic [W-1:0] act;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Monitor: pops expected items and compares, 1 ns after the falling edge.
  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      cur = q.pop_front();
      case (cur.sel)
        OBS_RD:   act = busRdData;
        OBS_IRQA: act = W'(irqA);
        OBS_IRQB: act = W'(irqB);
        OBS_OE:   act = pinOe;
        default:  act = pinOut;
      endcase
      checks++;
      if ((act & cur.msk) !== (cur.exp & cur.msk)) begin
        errors++;
        $display("FAIL %s: actual 0x%h expected 0x%h (mask 0x%h)",
                 cur.tag, act & cur.msk, cur.exp & cur.msk, cur.msk);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  // Driver: sets up the observation and queues the expected value.
  task automatic expect_(input int sel, input logic [3:0] a,
                         input logic [W-1:0] e, input logic [W-1:0] m,
                         input string tag);
    item_t it;
    @(negedge clk);
    busAddr = a;
    it.sel = sel; it.exp = e; it.msk = m; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setPins(input logic [W-1:0] v);
    @(negedge clk);
    pinIn = v;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;

    // R1 reset state
    expect_(OBS_RD,   4'd0,  '0, '1, "R1 data");
    expect_(OBS_RD,   4'd4,  '0, '1, "R1 maskA");
    expect_(OBS_RD,   4'd8,  '0, '1, "R1 maskB");
    expect_(OBS_RD,   4'd12, '0, '1, "R1 dir");
    expect_(OBS_OE,   4'd0,  '0, '1, "R1 pinOe");
    expect_(OBS_IRQA, 4'd0,  '0, '1, "R1 irqA");
    expect_(OBS_IRQB, 4'd0,  '0, '1, "R1 irqB");

    // R2 / R3 direction
    wr(4'd12, 16'h00FF);
    expect_(OBS_RD, 4'd12, 16'h00FF, '1, "R3 dir readback");
    expect_(OBS_OE, 4'd0,  16'h00FF, '1, "R2 pinOe");

    // R4 set; level inputs ignore it (R8)
    wr(4'd1, 16'h0F11);
    expect_(OBS_RD,  4'd0, 16'h0011, '1, "R4 set / R8 inputs unchanged");
    expect_(OBS_OUT, 4'd0, 16'h0011, 16'h00FF, "R2 pinOut");
    wr(4'd2, 16'h0001);
    expect_(OBS_RD, 4'd0, 16'h0010, '1, "R5 clear");
    wr(4'd3, 16'h0003);
    expect_(OBS_RD, 4'd0, 16'h0013, '1, "R6 toggle");
    wr(4'd0, 16'h00A5);
    expect_(OBS_RD, 4'd0, 16'h00A5, '1, "R3 direct data");
    expect_(OBS_RD, 4'd1, 16'h00A5, '1, "R3 read via set address");

    // R7 mask ports, R12 interrupts
    wr(4'd5, 16'h0005);
    expect_(OBS_RD, 4'd4, 16'h0005, '1, "R7 maskA set");
    wr(4'd6, 16'h0001);
    expect_(OBS_RD, 4'd4, 16'h0004, '1, "R7 maskA clear");
    wr(4'd7, 16'h0003);
    expect_(OBS_RD, 4'd5, 16'h0007, '1, "R7 maskA toggle");
    expect_(OBS_IRQA, 4'd0, 16'h0001, '1, "R12 irqA data&mask");
    wr(4'd8, 16'h0100);
    expect_(OBS_RD,   4'd8, 16'h0100, '1, "R3 direct maskB");
    expect_(OBS_IRQB, 4'd0, 16'h0000, '1, "R12 irqB no overlap");
    wr(4'd9, 16'h0002);
    expect_(OBS_RD, 4'd8, 16'h0102, '1, "R7 maskB set");
    wr(4'd10, 16'h0100);
    expect_(OBS_RD, 4'd8, 16'h0002, '1, "R7 maskB clear");
    wr(4'd11, 16'h0001);
    expect_(OBS_RD,   4'd11, 16'h0003, '1, "R7 maskB toggle");
    expect_(OBS_IRQB, 4'd0, 16'h0001, '1, "R12 irqB data&mask");
    wr(4'd2, 16'h00FF);
    expect_(OBS_IRQA, 4'd0, 16'h0000, '1, "R12 irqA cleared");
    expect_(OBS_IRQB, 4'd0, 16'h0000, '1, "R12 irqB cleared");
    wr(4'd1, 16'h0002);
    expect_(OBS_IRQA, 4'd0, 16'h0001, '1, "R12 software irqA");
    expect_(OBS_IRQB, 4'd0, 16'h0001, '1, "R12 software irqB");
    wr(4'd2, 16'h0002);

    // R8 level input
    setPins(16'h0100);
    idle(2);
    expect_(OBS_RD, 4'd0, 16'h0100, 16'h0100, "R8 level follows pin");
    wr(4'd13, 16'h0100);
    expect_(OBS_RD, 4'd0, 16'h0000, 16'h0100, "R8 level polarity");
    wr(4'd13, 16'h0000);
    setPins(16'h0000);
    idle(3);

    // R9 rising only
    wr(4'd14, 16'h0200);
    setPins(16'h0200);
    idle(2);
    expect_(OBS_RD, 4'd0, 16'h0200, 16'h0200, "R9 rising latched");
    wr(4'd5, 16'h0200);
    expect_(OBS_IRQA, 4'd0, 16'h0001, '1, "R12 irqA from input edge");
    wr(4'd2, 16'h0200);
    expect_(OBS_RD,   4'd0, 16'h0000, 16'h0200, "R5 clear latched edge");
    expect_(OBS_IRQA, 4'd0, 16'h0000, '1, "R12 irqA after clear");
    setPins(16'h0000);
    idle(3);
    expect_(OBS_RD, 4'd0, 16'h0000, 16'h0200, "R9 falling ignored");

    // R10 both edges
    wr(4'd14, 16'h0600);
    wr(4'd15, 16'h0400);
    setPins(16'h0400);
    idle(2);
    expect_(OBS_RD, 4'd0, 16'h0400, 16'h0400, "R10 rising latched");
    wr(4'd2, 16'h0400);
    expect_(OBS_RD, 4'd0, 16'h0000, 16'h0400, "R10 cleared");
    setPins(16'h0000);
    idle(2);
    expect_(OBS_RD, 4'd0, 16'h0400, 16'h0400, "R10 falling latched");
    wr(4'd2, 16'h0400);

    // R11 inverted edge pin
    wr(4'd13, 16'h0800);
    wr(4'd14, 16'h0E00);
    expect_(OBS_RD, 4'd13, 16'h0800, '1, "R3 polarity readback");
    wr(4'd2, 16'h0800);
    expect_(OBS_RD, 4'd0, 16'h0000, 16'h0800, "R11 cleared");
    setPins(16'h0800);
    idle(3);
    expect_(OBS_RD, 4'd0, 16'h0000, 16'h0800, "R11 rising pin ignored");
    setPins(16'h0000);
    idle(2);
    expect_(OBS_RD, 4'd0, 16'h0800, 16'h0800, "R11 falling pin latched");

    idle(3);
    if (!finished) begin
      finished = 1;
      summary();
      $finish;
    end
  end

endmodule